// File: doc/BRIEF.md
# Mains Range Classifier with Dwell Blanking

This block decides whether the rectified mains input sits in the low-line or the high-line range. It watches two already-synchronized comparator flags taken from the scaled input-voltage sense: one that is set while the sense level is under the lower threshold (about 2.3 V), and one that is set while it is over the upper threshold (about 2.4 V). With the usual divider these levels sit near 184 V and 192 V rms of line voltage. The gap between the two thresholds gives a hysteresis band.

The two moves are deliberately lopsided. A single sample above the upper threshold switches the block to high-line on the next clock. The move back to low-line needs the lower-threshold flag to stay set without a break for longer than a blanking interval (25 ms in the intended system, set as a cycle count). A rectified sine dips under the lower threshold near every zero crossing, so the blanking interval must be longer than a half-line period. The registered range flag and a derived valley ordinal go to the valley scheduler. It turns the switch on at the first valley in low-line and at the second valley in high-line.

Top module: `line_range_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `highLine` is 0 and `valleyOrdinal` is 1.
- R2: When `aboveHighSync` is 1 at a rising clock edge, `highLine` is 1 after that edge, whatever the earlier dwell.
- R3: From high-line, `highLine` falls to 0 only after `belowLowSync` has been 1 (with `aboveHighSync` 0) at BLANK_CYCLES+1 consecutive rising edges. It falls after the last of those edges and not before.
- R4: Any edge with `belowLowSync` at 0 restarts the dwell, so the count for R3 begins again from zero.
- R5: With both flags at 0, `highLine` holds its value.
- R6: `valleyOrdinal` is the unsigned value 1 while `highLine` is 0 and 2 while `highLine` is 1.
- R7: If both flags are 1 at the same edge, the upper flag wins: `highLine` becomes 1 and the dwell restarts.
- R8: In low-line, `belowLowSync` has no effect: `highLine` stays 0, however long the flag is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| belowLowSync | input | 1 | Synchronized flag: sense under lower threshold |
| aboveHighSync | input | 1 | Synchronized flag: sense over upper threshold |
| highLine | output | 1 | Registered range: 1 = high-line, 0 = low-line |
| valleyOrdinal | output | VALLEY_W | Valley at which to turn on (1 or 2) |

## Verification
Every result is due exactly one rising edge after the flags that cause it. A sample of `aboveHighSync` shows up in `highLine` after that same edge. The move to low-line shows after the (BLANK_CYCLES+1)-th consecutive below-threshold edge, and `valleyOrdinal` follows `highLine` in the same cycle. The driver applies one flag pair per cycle at the falling edge and pushes the expected range for the coming edge into a queue. The monitor pops one entry a little after each rising edge, so each expectation is compared against the single edge it predicts. The bench runs with a short blanking count, so that edges at exactly BLANK_CYCLES and BLANK_CYCLES+1 can be reached, along with an interrupted dwell and a periodic dip pattern.

// File: rtl/line_range_pkg.sv
package line_range_pkg;

  typedef enum logic {
    RANGE_LOW  = 1'b0,
    RANGE_HIGH = 1'b1
  } rangeState_t;

  typedef struct packed {
    logic clearDwell;
    logic stepDwell;
  } dwellCtrl_t;

endpackage

// File: rtl/lrd_dwell_dp.sv
module lrd_dwell_dp
  import line_range_pkg::*;
#(
  parameter int BLANK_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dwellCtrl_t ctrl,
  output logic       dwellDone
);
  localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLANK_CYCLES);

  logic [CNT_W-1:0] dwellCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (ctrl.clearDwell) begin
      dwellCnt <= '0;
    end else if (ctrl.stepDwell && dwellCnt != LIMIT) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  assign dwellDone = (dwellCnt == LIMIT);

  // Count never runs past the blanking limit (R3)
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    dwellCnt <= LIMIT);

  // A clear strobe empties the dwell on the next cycle (R4)
  assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearDwell |=> (dwellCnt == '0));

endmodule

// File: rtl/lrd_range_ctrl.sv
module lrd_range_ctrl
  import line_range_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        belowLow,
  input  logic        aboveHigh,
  input  logic        dwellDone,
  output dwellCtrl_t  ctrl,
  output rangeState_t range
);
  rangeState_t rangeNext;

  always_comb begin
    rangeNext       = range;
    ctrl.clearDwell = 1'b1;
    ctrl.stepDwell  = 1'b0;
    if (aboveHigh) begin
      rangeNext = RANGE_HIGH;
    end else if (range == RANGE_HIGH && belowLow) begin
      if (dwellDone) begin
        rangeNext = RANGE_LOW;
      end else begin
        ctrl.clearDwell = 1'b0;
        ctrl.stepDwell  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) range <= RANGE_LOW;
    else       range <= rangeNext;
  end

  // Upper threshold crossing is honoured on the very next cycle (R2)
  assert_fast_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    aboveHigh |=> (range == RANGE_HIGH));

  // Falling to low-line requires a completed dwell with the low flag set (R3)
  assert_low_needs_dwell_R3: assert property (@(posedge clk) disable iff (!rstN)
    (range == RANGE_HIGH && !(belowLow && !aboveHigh && dwellDone)) |=> (range == RANGE_HIGH));

  // Low-line is left only through the upper flag (R8)
  assert_low_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (range == RANGE_LOW && !aboveHigh) |=> (range == RANGE_LOW));

endmodule

// File: rtl/line_range_detect.sv
module line_range_detect
  import line_range_pkg::*;
#(
  parameter int BLANK_CYCLES = 1250000,
  parameter int VALLEY_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                belowLowSync,
  input  logic                aboveHighSync,
  output logic                highLine,
  output logic [VALLEY_W-1:0] valleyOrdinal
);
  localparam logic [VALLEY_W-1:0] VALLEY_LOW_LINE  = VALLEY_W'(1);
  localparam logic [VALLEY_W-1:0] VALLEY_HIGH_LINE = VALLEY_W'(2);

  dwellCtrl_t  dwellCtrl;
  logic        dwellDone;
  rangeState_t range;

  lrd_range_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .belowLow  (belowLowSync),
    .aboveHigh (aboveHighSync),
    .dwellDone (dwellDone),
    .ctrl      (dwellCtrl),
    .range     (range)
  );

  lrd_dwell_dp #(.BLANK_CYCLES(BLANK_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dwellCtrl),
    .dwellDone (dwellDone)
  );

  assign highLine      = (range == RANGE_HIGH);
  assign valleyOrdinal = highLine ? VALLEY_HIGH_LINE : VALLEY_LOW_LINE;

endmodule

// File: tb/tb_line_range_detect.sv
module tb_line_range_detect;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowLowSync = 1'b0;
  logic aboveHighSync = 1'b0;
  logic highLine;
  logic [1:0] valleyOrdinal;

  always #10 clk = ~clk;

  line_range_detect #(.BLANK_CYCLES(N), .VALLEY_W(2)) dut (
    .clk(clk), .rstN(rstN), .belowLowSync(belowLowSync),
    .aboveHighSync(aboveHighSync), .highLine(highLine),
    .valleyOrdinal(valleyOrdinal)
  );

  typedef struct { bit expHigh; string tag; } expItem_t;
  expItem_t expQ[$];

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  bit modelHigh = 1'b0;
  int modelCnt = 0;

  task automatic compareNow(bit expHigh, string tag);
    logic [1:0] expV;
    expV = expHigh ? 2'd2 : 2'd1;
    vectors++;
    if (highLine !== expHigh) begin
      misses++;
      $display("FAIL %s highLine actual=%0b expected=%0b", tag, highLine, expHigh);
    end
    vectors++;
    if (valleyOrdinal !== expV) begin
      misses++;
      $display("FAIL R6 (%s) valleyOrdinal actual=%0d expected=%0d", tag, valleyOrdinal, expV);
    end
  endtask

  task automatic step(bit b, bit a, string tag);
    expItem_t it;
    @(negedge clk);
    belowLowSync  = b;
    aboveHighSync = a;
    if (a) begin
      modelHigh = 1'b1; modelCnt = 0;
    end else if (modelHigh && b) begin
      if (modelCnt == N) begin modelHigh = 1'b0; modelCnt = 0; end
      else modelCnt++;
    end else begin
      modelCnt = 0;
    end
    it.expHigh = modelHigh;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic repeatStep(int n, bit b, bit a, string tag);
    for (int i = 0; i < n; i++) step(b, a, tag);
  endtask

  // Monitor: one expectation per rising edge, sampled shortly after it
  always @(posedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      #2;
      it = expQ.pop_front();
      compareNow(it.expHigh, it.tag);
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #200000;
    vectors++;
    misses++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compareNow(1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    #12 compareNow(1'b0, "R1 after reset");
    repeatStep(3, 0, 0, "R5 hold low");
    repeatStep(N + 10, 1, 0, "R8 below while low");
    step(0, 1, "R2 first crossing");
    repeatStep(5, 0, 0, "R5 hold high");
    repeatStep(N, 1, 0, "R3 dwell not yet done");
    step(1, 0, "R3 dwell completes");
    repeatStep(2, 1, 0, "R8 stays low");
    step(0, 1, "R2 back to high");
    repeatStep(N, 1, 0, "R4 partial dwell");
    step(0, 0, "R4 dwell break");
    repeatStep(N, 1, 0, "R4 restarted dwell");
    step(1, 0, "R4 restarted dwell completes");
    step(0, 1, "R2 rise again");
    repeatStep(N - 3, 1, 0, "R7 dwell before tie");
    step(1, 1, "R7 both flags");
    repeatStep(N, 1, 0, "R7 restarted after tie");
    step(1, 0, "R7 completes after tie");
    step(0, 1, "R2 rise for ripple");
    for (int k = 0; k < 6; k++) begin
      repeatStep(N - 4, 1, 0, "R4 zero-crossing dip");
      repeatStep(8, 0, 0, "R5 crest");
    end
    step(0, 0, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule